// File: doc/BRIEF.md
# Parallel-Prefix Lookahead Adder

This block adds two unsigned WIDTH-bit operands and a carry input. It returns a WIDTH-bit sum and a carry output. There are no registers, so the outputs follow the present inputs within the same cycle. The carry network has log2(WIDTH) merge levels, which keeps the logic depth low on wide datapaths.

Each bit position first forms a generate term (both operand bits set) and a propagate term (operand bits differ). The carry input is folded into bit 0 as if it were a generate from one position below the word. Every merge level doubles the span that each group term covers. A group whose lower partner would fall below bit 0 keeps its value and covers only the bits that exist. After the last level, the group generate at bit i is the carry out of bit i. Each sum bit is the propagate term XOR the carry into that bit.

Top module: `ppa_adder`

## Requirements
- R1: `sumOut` equals the low WIDTH bits of `opA + opB + carryIn`, treating all three as unsigned.
- R2: `carryOut` equals bit WIDTH of `opA + opB + carryIn`.
- R3: With both operands zero, `sumOut` equals `carryIn` in bit 0 with all other bits zero, and `carryOut` is 0.
- R4: When every bit pair differs (`opB == ~opA`), the carry input passes through the whole word. With `carryIn`=0 the sum is all ones and `carryOut`=0. With `carryIn`=1 the sum is zero and `carryOut`=1.
- R5: With both operands all ones, `carryOut` is 1 and `sumOut` is all ones except bit 0, which equals `carryIn`.
- R6: The outputs depend only on the present inputs. Applying a vector again after a different vector gives the same result as the first time.
- R7: Any power-of-two WIDTH of 2 or more is supported. At WIDTH=4, all 512 combinations of operands and carry input give the correct sum and carry.
- R8: A carry made only in the top bit (both operands equal to 1 shifted left by WIDTH-1, `carryIn`=0) gives `sumOut`=0 and `carryOut`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Low WIDTH bits of the sum |
| carryOut | output | 1 | Carry out of the top bit |

## Verification
The embedded checks assume that the operands and the carry input have settled to known two-state values whenever logic evaluates. They also assume that WIDTH is a power of two, so that the span-doubling levels cover the whole word. The stimulus changes inputs only once per clock, just after the rising edge, and applies only defined 0/1 values. Results are compared half a period later, so no check sees a half-updated operand.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  localparam int MIN_WIDTH = 2;

  function automatic int levelsFor(input int width);
    return $clog2(width);
  endfunction

endpackage

// File: rtl/ppa_bitpg.sv
module ppa_bitpg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] bitProp,
  output logic [WIDTH-1:0] foldGen
);

  logic [WIDTH-1:0] rawGen;

  assign rawGen  = opA & opB;
  assign bitProp = opA ^ opB;

  // carry input behaves as a generate one position below bit 0
  assign foldGen = {rawGen[WIDTH-1:1], rawGen[0] | (bitProp[0] & carryIn)};

  // R1: a position cannot both create and pass a carry
  always_comb begin
    a_r1_gen_prop_exclusive: assert ((rawGen & bitProp) == '0);
  end

endmodule

// File: rtl/ppa_prefix.sv
module ppa_prefix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] genIn,
  input  logic [WIDTH-1:0] propIn,
  output logic [WIDTH-1:0] grpGen,
  output logic [WIDTH-1:0] grpProp
);

  localparam int LEVELS = ppa_pkg::levelsFor(WIDTH);

  logic [LEVELS:0][WIDTH-1:0] lvlG;
  logic [LEVELS:0][WIDTH-1:0] lvlP;

  assign lvlG[0] = genIn;
  assign lvlP[0] = propIn;

  for (genvar k = 0; k < LEVELS; k++) begin : g_level
    localparam int SPAN = 1 << k;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SPAN) begin : g_merge
        assign lvlG[k+1][i] = lvlG[k][i] | (lvlP[k][i] & lvlG[k][i-SPAN]);
        assign lvlP[k+1][i] = lvlP[k][i] & lvlP[k][i-SPAN];
      end else begin : g_pass
        assign lvlG[k+1][i] = lvlG[k][i];
        assign lvlP[k+1][i] = lvlP[k][i];
      end
    end

    // R1: a group newly generating at the wider span must have propagated at the narrower one
    always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
        if (lvlG[k+1][i] && !lvlG[k][i])
          a_r1_merge_needs_prop: assert (lvlP[k][i]);
        if (lvlP[k+1][i])
          a_r1_prop_narrows: assert (lvlP[k][i]);
      end
    end
  end

  assign grpGen  = lvlG[LEVELS];
  assign grpProp = lvlP[LEVELS];

endmodule

// File: rtl/ppa_sum.sv
module ppa_sum #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] bitProp,
  input  logic [WIDTH-1:0] grpGen,
  input  logic [WIDTH-1:0] grpProp,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] carryInto;

  assign carryInto = {grpGen[WIDTH-2:0], carryIn};
  assign sumOut    = bitProp ^ carryInto;
  assign carryOut  = grpGen[WIDTH-1];

  // R4: a run of propagating bits from bit 0 hands the carry input straight up
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      if (grpProp[i])
        a_r4_prop_run_passes_cin: assert (grpGen[i] == carryIn);
    end
  end

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] bitProp;
  logic [WIDTH-1:0] foldGen;
  logic [WIDTH-1:0] grpGen;
  logic [WIDTH-1:0] grpProp;

  ppa_bitpg #(.WIDTH(WIDTH)) pg_i (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .bitProp (bitProp),
    .foldGen (foldGen)
  );

  ppa_prefix #(.WIDTH(WIDTH)) tree_i (
    .genIn   (foldGen),
    .propIn  (bitProp),
    .grpGen  (grpGen),
    .grpProp (grpProp)
  );

  ppa_sum #(.WIDTH(WIDTH)) sum_i (
    .bitProp  (bitProp),
    .grpGen   (grpGen),
    .grpProp  (grpProp),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  logic [WIDTH:0] refTotal;
  assign refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    a_r1_sum_matches:   assert (sumOut == refTotal[WIDTH-1:0]);
    a_r2_carry_matches: assert (carryOut == refTotal[WIDTH]);
  end

endmodule

// File: tb/ppa_adder_tb.sv
`timescale 1ns/1ps
module ppa_adder_tb_top;

  localparam int BIG   = 32;
  localparam int SMALL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [BIG-1:0]   opA = '0, opB = '0;
  logic             cin = 1'b0;
  logic [BIG-1:0]   sumBig;
  logic             coutBig;
  logic [SMALL-1:0] sumSmall;
  logic             coutSmall;

  ppa_adder #(.WIDTH(BIG)) dut_i (
    .opA(opA), .opB(opB), .carryIn(cin), .sumOut(sumBig), .carryOut(coutBig)
  );

  ppa_adder #(.WIDTH(SMALL)) dutSmall_i (
    .opA(opA[SMALL-1:0]), .opB(opB[SMALL-1:0]), .carryIn(cin),
    .sumOut(sumSmall), .carryOut(coutSmall)
  );

  typedef struct {
    logic [BIG:0]   expBig;
    logic [SMALL:0] expSmall;
    string          tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic drive(input logic [BIG-1:0] a, input logic [BIG-1:0] b,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    #0.5;
    opA = a; opB = b; cin = c;
    it.expBig   = {1'b0, a} + {1'b0, b} + {{BIG{1'b0}}, c};
    it.expSmall = {1'b0, a[SMALL-1:0]} + {1'b0, b[SMALL-1:0]} + {{SMALL{1'b0}}, c};
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if ({coutBig, sumBig} !== it.expBig) begin
        bad++;
        $display("FAIL %s width=%0d actual=%h expected=%h", it.tag, BIG,
                 {coutBig, sumBig}, it.expBig);
      end
      total++;
      if ({coutSmall, sumSmall} !== it.expSmall) begin
        bad++;
        $display("FAIL %s width=%0d actual=%h expected=%h", it.tag, SMALL,
                 {coutSmall, sumSmall}, it.expSmall);
      end
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [BIG-1:0] ONES = '1;
  localparam logic [BIG-1:0] TOPB = {1'b1, {(BIG-1){1'b0}}};

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R3: zero operands, both carry values
    drive('0, '0, 1'b0, "R3");
    drive('0, '0, 1'b1, "R3");
    // R4: complementary operands pass the carry input across all bits
    drive(32'h5A5A_0F0F, ~32'h5A5A_0F0F, 1'b0, "R4");
    drive(32'h5A5A_0F0F, ~32'h5A5A_0F0F, 1'b1, "R4");
    drive(ONES, '0, 1'b1, "R4");
    drive('0, ONES, 1'b0, "R4");
    // R5: both all ones
    drive(ONES, ONES, 1'b0, "R5");
    drive(ONES, ONES, 1'b1, "R5");
    // R8: carry made only in the top bit
    drive(TOPB, TOPB, 1'b0, "R8");
    // R6: same vector after a different history
    drive(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R6");
    drive(ONES, 32'h0000_0001, 1'b0, "R6");
    drive(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, "R6");
    // R7: exhaustive at the small width, random upper bits
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          drive({$urandom(), 4'(a)} , {$urandom(), 4'(b)}, 1'(c), "R7");
    // R1 R2: random vectors
    for (int n = 0; n < 3000; n++)
      drive($urandom(), $urandom(), 1'($urandom()), "R1 R2");
    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule